// File: doc/BRIEF.md
# Byte-Wide RAM with Embedded BCD Calendar Clock

This block models a byte-wide static memory whose eight highest addresses hold a real-time clock and calendar in packed BCD. A host reaches it through an asynchronous-memory style bus: active-low chip select, output enable and write enable, an address and a byte of write and read data. The bus is sampled on the system clock, so a write takes effect at the rising edge on which chip select and write enable are both low. Reads are combinational from the address.

A single-cycle `sec_tick` pulse advances the time. Seconds, minutes, hours, day of week, date, month, year and century each roll over at their limits, and the carry passes upward. Three control bits share bytes with the time fields. The stop bit halts counting. The read bit freezes what the host sees while counting carries on behind it. The write bit opens a staging copy that the host edits, and clearing the bit commits that copy to the counters. Addresses below the clock window act as plain byte storage, mirrored every `2**STORE_AW` bytes.

Top module: `bcd_clock_ram`

## Requirements
- R1: After reset the clock reads 20 00-01-01, day 1, 00:00:00 with all control bits clear. Byte 0x1FF8 reads 0x20, 0x1FF9 to 0x1FFB read 0x00, 0x1FFC reads 0x81 (battery flag 1, day 1), 0x1FFD and 0x1FFE read 0x01, and 0x1FFF reads 0x00.
- R2: `rd_drive` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. Whenever `rd_drive` is 0, `rd_data` is 0x00.
- R3: A write to an address below 0x1FF8 stores the byte and it reads back unchanged. Storage is indexed by the low `STORE_AW` address bits, so with `STORE_AW`=6, addresses 0x0005 and 0x0045 alias, and so do 0x1FF7 and 0x0037.
- R4: While the write bit is 0, writes leave the time fields unchanged. The control bits stay writable at all times: write bit (0x1FF8 bit 7), read bit (0x1FF8 bit 6), stop bit (0x1FF9 bit 7) and frequency-test bit (0x1FFC bit 6).
- R5: Setting the write bit copies the running time into a staging copy, which reads and writes then address. Counting stops while the bit is set. When the bit is cleared, the staged values are loaded into the counters on the next cycle, and counting resumes from them.
- R6: Seconds and minutes roll from 0x59 to 0x00, and hours from 0x23 to 0x00. Each rollover carries into the next field, and a units digit of 9 carries into the tens digit.
- R7: At midnight the day of week wraps from 7 to 1. The date rolls to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, and 31 for the other months except February. At the end of month 12 the month rolls to 01.
- R8: February ends on 29 when the BCD year is a multiple of four (00 counts), and on 28 otherwise.
- R9: Year 0x99 rolls to 0x00 and carries into the century. Century 0x39 rolls to 0x00.
- R10: Setting the read bit freezes the visible time at its value in that cycle, while counting goes on. Clearing the bit shows the live time again.
- R11: While the stop bit is 1, ticks do not change the time. The bit reads back in 0x1FF9 bit 7.
- R12: Unused bits are forced to zero when staged (hour bits 7:6, minutes bit 7, date bits 7:6, month bits 7:5, day bits 5:3, century bits are covered by the control bits). 0x1FFC bit 7 always reads the `BATT_OK` parameter, and bit 6 reads back the frequency-test bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse advancing the time by one second |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, 0 when not driven |
| rd_drive | output | 1 | High while the block would drive the data bus |

## Verification
The bench builds the block with `STORE_AW`=6 and keeps the default 13-bit address, so the aliasing of low storage addresses, including the byte just below the clock window, comes within reach of a few writes. It loads times close to each rollover and gives a single tick: year end with century carry, February in leap and common years (00, 24, 96 and 23), a 30-day month, and an hour carry. It also checks the stop, read and write bits, and the masking of unused bits, through ordinary bus reads.

// File: rtl/bcdrtc_pkg.sv
package bcdrtc_pkg;

   typedef struct packed {
      logic [7:0] cent;
      logic [7:0] year;
      logic [7:0] mon;
      logic [7:0] date;
      logic [7:0] dow;
      logic [7:0] hour;
      logic [7:0] min;
      logic [7:0] sec;
   } rtc_time_t;

   // byte slots inside the clock window (low three address bits)
   localparam logic [2:0] SLOT_CENT = 3'd0;
   localparam logic [2:0] SLOT_SEC  = 3'd1;
   localparam logic [2:0] SLOT_MIN  = 3'd2;
   localparam logic [2:0] SLOT_HOUR = 3'd3;
   localparam logic [2:0] SLOT_DOW  = 3'd4;
   localparam logic [2:0] SLOT_DATE = 3'd5;
   localparam logic [2:0] SLOT_MON  = 3'd6;
   localparam logic [2:0] SLOT_YEAR = 3'd7;

   function automatic logic [7:0] bcd_next(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic leap_year(input logic [7:0] y);
      case (y[3:0])
         4'd0, 4'd4, 4'd8: return ~y[4];
         4'd2, 4'd6:       return y[4];
         default:          return 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] year);
      case (mon)
         8'h02:                      return leap_year(year) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic logic [7:0] field_get(input rtc_time_t t, input logic [2:0] s);
      case (s)
         SLOT_CENT: return t.cent;
         SLOT_SEC:  return t.sec;
         SLOT_MIN:  return t.min;
         SLOT_HOUR: return t.hour;
         SLOT_DOW:  return t.dow;
         SLOT_DATE: return t.date;
         SLOT_MON:  return t.mon;
         default:   return t.year;
      endcase
   endfunction

endpackage

// File: rtl/bcdrtc_store.sv
module bcdrtc_store #(
   parameter int AW = 8,
   parameter int DW = 8,
   localparam int PA = (AW > 0) ? AW : 1
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [PA-1:0] addr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data
);

   generate
      if (AW > 0) begin : g_mem
         localparam int DEPTH = 1 << AW;
         logic [DW-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (wr_en) mem[addr] <= wr_data;
         end

         assign rd_data = mem[addr];
      end else begin : g_none
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, wr_en, addr, wr_data};
         assign rd_data   = '0;
      end
   endgenerate

endmodule

// File: rtl/bcdrtc_counter.sv
module bcdrtc_counter
   import bcdrtc_pkg::*;
#(
   parameter logic [63:0] RST_TIME = 64'h2000_0101_0100_0000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      adv,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t live
);

   rtc_time_t nxt;

   always_comb begin
      nxt = live;
      if (live.sec != 8'h59) begin
         nxt.sec = bcd_next(live.sec);
      end else begin
         nxt.sec = 8'h00;
         if (live.min != 8'h59) begin
            nxt.min = bcd_next(live.min);
         end else begin
            nxt.min = 8'h00;
            if (live.hour != 8'h23) begin
               nxt.hour = bcd_next(live.hour);
            end else begin
               nxt.hour = 8'h00;
               nxt.dow  = (live.dow >= 8'h07) ? 8'h01 : live.dow + 8'h01;
               if (live.date != month_end(live.mon, live.year)) begin
                  nxt.date = bcd_next(live.date);
               end else begin
                  nxt.date = 8'h01;
                  if (live.mon != 8'h12) begin
                     nxt.mon = bcd_next(live.mon);
                  end else begin
                     nxt.mon = 8'h01;
                     if (live.year != 8'h99) begin
                        nxt.year = bcd_next(live.year);
                     end else begin
                        nxt.year = 8'h00;
                        nxt.cent = (live.cent == 8'h39) ? 8'h00 : bcd_next(live.cent);
                     end
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    live <= rtc_time_t'(RST_TIME);
      else if (load) live <= load_val;
      else if (adv)  live <= nxt;
   end

endmodule

// File: rtl/bcdrtc_regs.sv
module bcdrtc_regs
   import bcdrtc_pkg::*;
#(
   parameter logic BATT_OK = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] sel,
   input  logic [7:0] wr_data,
   input  rtc_time_t  live,
   output logic [7:0] rd_byte,
   output rtc_time_t  hold_t,
   output rtc_time_t  vis_t,
   output logic       w_bit,
   output logic       r_bit,
   output logic       osc_stop,
   output logic       load
);

   localparam int NSLOT = 8;
   localparam logic [7:0] FIELD_MASK [NSLOT] =
      '{8'h3F, 8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};

   logic [7:0] live_b [NSLOT];
   logic [7:0] hold_b [NSLOT];
   logic [7:0] vis_b  [NSLOT];
   logic       ft_bit, w_prev;
   logic       w_nx, r_nx, capture, frozen;

   assign w_nx    = (wr_en && sel == SLOT_CENT) ? wr_data[7] : w_bit;
   assign r_nx    = (wr_en && sel == SLOT_CENT) ? wr_data[6] : r_bit;
   assign frozen  = w_bit | r_bit;
   assign capture = !frozen && (w_nx || r_nx);

   generate
      for (genvar i = 0; i < NSLOT; i++) begin : g_slot
         assign live_b[i] = field_get(live, 3'(i));
         assign vis_b[i]  = frozen ? hold_b[i] : live_b[i];

         always_ff @(posedge clk) begin
            if (!rst_n)
               hold_b[i] <= '0;
            else if (capture)
               hold_b[i] <= live_b[i];
            else if (wr_en && w_bit && sel == 3'(i))
               hold_b[i] <= wr_data & FIELD_MASK[i];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_bit    <= 1'b0;
         r_bit    <= 1'b0;
         osc_stop <= 1'b0;
         ft_bit   <= 1'b0;
         w_prev   <= 1'b0;
      end else begin
         w_bit  <= w_nx;
         r_bit  <= r_nx;
         w_prev <= w_bit;
         if (wr_en && sel == SLOT_SEC) osc_stop <= wr_data[7];
         if (wr_en && sel == SLOT_DOW) ft_bit   <= wr_data[6];
      end
   end

   assign load = w_prev && !w_bit;

   assign hold_t = {hold_b[SLOT_CENT], hold_b[SLOT_YEAR], hold_b[SLOT_MON], hold_b[SLOT_DATE],
                    hold_b[SLOT_DOW], hold_b[SLOT_HOUR], hold_b[SLOT_MIN], hold_b[SLOT_SEC]};
   assign vis_t  = {vis_b[SLOT_CENT], vis_b[SLOT_YEAR], vis_b[SLOT_MON], vis_b[SLOT_DATE],
                    vis_b[SLOT_DOW], vis_b[SLOT_HOUR], vis_b[SLOT_MIN], vis_b[SLOT_SEC]};

   always_comb begin
      case (sel)
         SLOT_CENT: rd_byte = {w_bit, r_bit, vis_b[SLOT_CENT][5:0]};
         SLOT_SEC:  rd_byte = {osc_stop, vis_b[SLOT_SEC][6:0]};
         SLOT_DOW:  rd_byte = {BATT_OK, ft_bit, vis_b[SLOT_DOW][5:0]};
         default:   rd_byte = vis_b[sel];
      endcase
   end

endmodule

// File: rtl/bcd_clock_ram.sv
module bcd_clock_ram
   import bcdrtc_pkg::*;
#(
   parameter int          ADDR_W   = 13,
   parameter int          DATA_W   = 8,
   parameter int          STORE_AW = 8,
   parameter logic        BATT_OK  = 1'b1,
   parameter logic [63:0] RST_TIME = 64'h2000_0101_0100_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_drive
);

   localparam int SA = (STORE_AW > 0) ? STORE_AW : 1;

   generate
      if (DATA_W != 8) begin : g_bad_dw
         $error("bcd_clock_ram: DATA_W must be 8");
      end
      if (ADDR_W < 4) begin : g_bad_aw
         $error("bcd_clock_ram: ADDR_W must be at least 4");
      end
      if (STORE_AW < 0 || STORE_AW >= ADDR_W || STORE_AW > 12) begin : g_bad_sw
         $error("bcd_clock_ram: STORE_AW out of range");
      end
   endgenerate

   logic       clk_hit, bus_wr;
   logic [7:0] reg_byte, mem_byte;
   logic       w_bit, r_bit, osc_stop, load, adv;
   rtc_time_t  live_t, hold_t, vis_t;

   assign clk_hit  = &addr[ADDR_W-1:3];
   assign bus_wr   = !ce_n && !we_n;
   assign rd_drive = !ce_n && !oe_n && we_n;

   bcdrtc_store #(.AW(STORE_AW), .DW(DATA_W)) u_store (
      .clk     (clk),
      .wr_en   (bus_wr && !clk_hit),
      .addr    (addr[SA-1:0]),
      .wr_data (wr_data),
      .rd_data (mem_byte)
   );

   bcdrtc_regs #(.BATT_OK(BATT_OK)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr && clk_hit),
      .sel      (addr[2:0]),
      .wr_data  (wr_data),
      .live     (live_t),
      .rd_byte  (reg_byte),
      .hold_t   (hold_t),
      .vis_t    (vis_t),
      .w_bit    (w_bit),
      .r_bit    (r_bit),
      .osc_stop (osc_stop),
      .load     (load)
   );

   assign adv = sec_tick && !osc_stop && !w_bit && !load;

   bcdrtc_counter #(.RST_TIME(RST_TIME)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .load     (load),
      .load_val (hold_t),
      .live     (live_t)
   );

   assign rd_data = rd_drive ? (clk_hit ? reg_byte : mem_byte) : '0;

endmodule

module bcd_clock_ram_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we_n,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_drive,
   input logic              osc_stop,
   input logic              w_bit,
   input logic              r_bit,
   input logic              load,
   input logic              adv,
   input logic [63:0]       live_v,
   input logic [63:0]       vis_v
);

   // R2
   idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_drive |-> rd_data == '0);

   // R2
   write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || ce_n || oe_n) |-> !rd_drive);

   // R11
   stop_holds_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_stop && !load) |=> $stable(live_v));

   // R5
   write_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_bit |=> $stable(live_v));

   // R10
   snapshot_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (r_bit && !w_bit && $past(r_bit) && !$past(w_bit)) |-> $stable(vis_v));

   // R6
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && live_v[7:0] == 8'h59) |=> live_v[7:0] == 8'h00);

endmodule

bind bcd_clock_ram bcd_clock_ram_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce_n     (ce_n),
   .oe_n     (oe_n),
   .we_n     (we_n),
   .rd_data  (rd_data),
   .rd_drive (rd_drive),
   .osc_stop (osc_stop),
   .w_bit    (w_bit),
   .r_bit    (r_bit),
   .load     (load),
   .adv      (adv),
   .live_v   (live_t),
   .vis_v    (vis_t)
);

// File: tb/bcd_clock_ram_test.sv
module bcd_clock_ram_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic        ce_n = 1'b1;
   logic        oe_n = 1'b1;
   logic        we_n = 1'b1;
   logic [12:0] addr = '0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic        rd_drive;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] q_data [$];
   bit         q_drv  [$];
   string      q_tag  [$];
   event       mon_ev;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_clock_ram #(.STORE_AW(6)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .addr     (addr),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .rd_drive (rd_drive)
   );

   // monitor: pops expected items and compares them with the bus
   initial begin
      forever begin
         @(mon_ev);
         while (q_data.size() > 0) begin
            automatic logic [7:0] e = q_data.pop_front();
            automatic bit         v = q_drv.pop_front();
            automatic string      t = q_tag.pop_front();
            checks++;
            if (rd_data !== e || rd_drive !== v) begin
               errors++;
               $display("FAIL %s: data %h drive %b, expected data %h drive %b",
                        t, rd_data, rd_drive, e, v);
            end
         end
      end
   end

   task automatic wr(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wr_data = d;
      @(posedge clk);
      #1;
      ce_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic rd(input logic [12:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
      q_data.push_back(e); q_drv.push_back(1'b1); q_tag.push_back(tag);
      #1;
      -> mon_ev;
      #1;
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic bus_state(input logic c, input logic o, input logic w, input string tag);
      @(negedge clk);
      ce_n = c; oe_n = o; we_n = w; addr = 13'h0010; wr_data = 8'h00;
      q_data.push_back(8'h00); q_drv.push_back(1'b0); q_tag.push_back(tag);
      #1;
      -> mon_ev;
      @(posedge clk);
      #1;
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic tick();
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] c, input logic [7:0] y, input logic [7:0] mo,
                           input logic [7:0] da, input logic [7:0] dw, input logic [7:0] h,
                           input logic [7:0] mi, input logic [7:0] s);
      wr(13'h1FF8, 8'h80);
      wr(13'h1FF9, s);
      wr(13'h1FFA, mi);
      wr(13'h1FFB, h);
      wr(13'h1FFC, dw);
      wr(13'h1FFD, da);
      wr(13'h1FFE, mo);
      wr(13'h1FFF, y);
      wr(13'h1FF8, c);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset contents
      rd(13'h1FF8, 8'h20, "R1 century/control");
      rd(13'h1FF9, 8'h00, "R1 seconds");
      rd(13'h1FFA, 8'h00, "R1 minutes");
      rd(13'h1FFB, 8'h00, "R1 hours");
      rd(13'h1FFC, 8'h81, "R1 day");
      rd(13'h1FFD, 8'h01, "R1 date");
      rd(13'h1FFE, 8'h01, "R1 month");
      rd(13'h1FFF, 8'h00, "R1 year");

      // R2 bus gating
      bus_state(1'b0, 1'b1, 1'b1, "R2 output enable high");
      bus_state(1'b1, 1'b0, 1'b1, "R2 chip select high");
      bus_state(1'b0, 1'b0, 1'b0, "R2 write cycle");

      // R3 storage and mirroring
      wr(13'h0005, 8'hA5);
      wr(13'h0006, 8'h5A);
      rd(13'h0005, 8'hA5, "R3 store byte 5");
      rd(13'h0006, 8'h5A, "R3 store byte 6");
      wr(13'h0045, 8'h3C);
      rd(13'h0005, 8'h3C, "R3 alias 0x45 onto 0x05");
      wr(13'h1FF7, 8'h77);
      rd(13'h0037, 8'h77, "R3 alias 0x1FF7 onto 0x37");

      // R4 time field write ignored while write bit clear
      wr(13'h1FFF, 8'h55);
      rd(13'h1FFF, 8'h00, "R4 year write ignored");

      // R5 staging and load
      wr(13'h1FF8, 8'h80);
      rd(13'h1FF8, 8'hA0, "R5 write bit set, staged century");
      wr(13'h1FF9, 8'h59);
      wr(13'h1FFA, 8'h59);
      wr(13'h1FFB, 8'h23);
      wr(13'h1FFC, 8'h07);
      wr(13'h1FFD, 8'h31);
      wr(13'h1FFE, 8'h12);
      wr(13'h1FFF, 8'h99);
      rd(13'h1FF9, 8'h59, "R5 staged seconds visible");
      tick();
      wr(13'h1FF8, 8'h20);
      repeat (2) @(negedge clk);
      rd(13'h1FF9, 8'h59, "R5 loaded seconds, tick under write bit lost");
      rd(13'h1FFF, 8'h99, "R5 loaded year");
      rd(13'h1FF8, 8'h20, "R5 write bit cleared");

      // R7 R9 year end with century carry
      tick();
      rd(13'h1FF9, 8'h00, "R6 seconds wrap");
      rd(13'h1FFA, 8'h00, "R6 minutes wrap");
      rd(13'h1FFB, 8'h00, "R6 hours wrap");
      rd(13'h1FFC, 8'h81, "R7 day 7 to 1");
      rd(13'h1FFD, 8'h01, "R7 date 31 to 01");
      rd(13'h1FFE, 8'h01, "R7 month 12 to 01");
      rd(13'h1FFF, 8'h00, "R9 year 99 to 00");
      rd(13'h1FF8, 8'h21, "R9 century carry");

      // R8 February
      set_time(8'h21, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
      tick();
      rd(13'h1FFD, 8'h01, "R8 common year Feb 28 to date 01");
      rd(13'h1FFE, 8'h03, "R8 common year to March");
      rd(13'h1FFC, 8'h84, "R7 day 3 to 4");
      set_time(8'h21, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
      tick();
      rd(13'h1FFD, 8'h29, "R8 leap year 24 Feb 28 to 29");
      rd(13'h1FFE, 8'h02, "R8 leap year stays February");
      set_time(8'h21, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
      tick();
      rd(13'h1FFD, 8'h01, "R8 leap year Feb 29 to 01");
      rd(13'h1FFE, 8'h03, "R8 leap year to March");
      set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
      tick();
      rd(13'h1FFD, 8'h29, "R8 year 00 is leap");
      set_time(8'h21, 8'h96, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
      tick();
      rd(13'h1FFD, 8'h29, "R8 year 96 is leap");
      set_time(8'h21, 8'h10, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
      tick();
      rd(13'h1FFD, 8'h01, "R8 year 10 is common");

      // R7 thirty-day month
      set_time(8'h21, 8'h24, 8'h04, 8'h30, 8'h07, 8'h23, 8'h59, 8'h59);
      tick();
      rd(13'h1FFD, 8'h01, "R7 April 30 to date 01");
      rd(13'h1FFE, 8'h05, "R7 April to May");
      rd(13'h1FFC, 8'h81, "R7 day 7 to 1 again");

      // R6 hour carry and digit carry
      set_time(8'h21, 8'h24, 8'h05, 8'h10, 8'h02, 8'h09, 8'h59, 8'h59);
      tick();
      rd(13'h1FFB, 8'h10, "R6 hour 09 to 10");
      rd(13'h1FFA, 8'h00, "R6 minute 59 to 00");
      rd(13'h1FFD, 8'h10, "R6 date unchanged");
      repeat (10) tick();
      rd(13'h1FF9, 8'h10, "R6 seconds 09 to 10");
      rd(13'h1FFA, 8'h00, "R6 minutes unchanged");

      // R9 century 39 wraps
      set_time(8'h39, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
      tick();
      rd(13'h1FF8, 8'h00, "R9 century 39 to 00");
      rd(13'h1FFF, 8'h00, "R9 year to 00");

      // R10 read snapshot
      set_time(8'h21, 8'h24, 8'h06, 8'h15, 8'h03, 8'h12, 8'h30, 8'h10);
      wr(13'h1FF8, 8'h40);
      repeat (3) tick();
      rd(13'h1FF9, 8'h10, "R10 frozen seconds");
      rd(13'h1FF8, 8'h61, "R10 read bit set");
      wr(13'h1FF8, 8'h00);
      rd(13'h1FF9, 8'h13, "R10 live seconds after release");
      rd(13'h1FF8, 8'h21, "R4 century unchanged by control write");

      // R11 stop bit
      wr(13'h1FF9, 8'h80);
      rd(13'h1FF9, 8'h93, "R11 stop bit set, seconds kept");
      repeat (2) tick();
      rd(13'h1FF9, 8'h93, "R11 no advance while stopped");
      wr(13'h1FF9, 8'h00);
      tick();
      rd(13'h1FF9, 8'h14, "R11 advance after restart");

      // R12 masking, battery flag, frequency-test bit
      wr(13'h1FF8, 8'h80);
      wr(13'h1FFA, 8'hFF);
      rd(13'h1FFA, 8'h7F, "R12 minutes bit 7 masked");
      wr(13'h1FFB, 8'hFF);
      rd(13'h1FFB, 8'h3F, "R12 hour bits 7:6 masked");
      wr(13'h1FFD, 8'hFF);
      rd(13'h1FFD, 8'h3F, "R12 date bits 7:6 masked");
      wr(13'h1FFE, 8'hFF);
      rd(13'h1FFE, 8'h1F, "R12 month bits 7:5 masked");
      wr(13'h1FFC, 8'h7F);
      rd(13'h1FFC, 8'hC7, "R12 battery flag read-only, test bit set");
      wr(13'h1FFC, 8'h01);
      rd(13'h1FFC, 8'h81, "R12 test bit cleared");

      done = 1'b1;
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule